// File: doc/BRIEF.md
# PWM Output Software Force Unit

This block sits between the action logic of a two-output PWM generator and the output pins. It can override each of the two outputs (A and B) from software in two ways. A continuous override holds an output low or high for as long as it is enabled. A one-shot override drives the output to a chosen level and keeps it there until the generator's next action event on that output.

The continuous setting is double-buffered. The control word carries a shadow setting. A one-hot event mask decides which timer events (counter at zero, at period, at compare A, at compare B, or a sync pulse) copy the shadow setting into the active setting. An all-zero mask applies the shadow setting at once, and a freeze bit stops all copying. A one-shot override fires when its trigger bit in the control word changes value, in either direction. The control word is captured in a register on every clock. The raw levels pass through to the outputs combinationally unless an override applies.

Top module: `pwm_force_ovr`

## Requirements
- R1: After reset, with no override pending, each output equals its raw input level combinationally. Reset clears the captured control word, the active setting and the stored trigger bits.
- R2: A 2-bit force mode of 1 drives the output low and 2 drives it high. Modes 0 and 3 are both disabled. Continuous modes sit at control bits 7:6 (A) and 9:8 (B).
- R3: When the update mask (control bits 5:0) is zero, a new continuous setting on `ctrl_i` shows at the outputs after one rising clock edge.
- R4: Mask bit 0 selects the zero event, bit 1 the period event, bit 2 compare A, bit 3 compare B and bit 4 sync. On a clock edge where any selected event is high, the shadow setting is copied to the active setting. Events that are not selected have no effect.
- R5: While mask bit 5 is set, the active continuous setting does not change, whatever events occur and whatever other mask bits are set.
- R6: A one-shot override fires when its trigger bit changes in either direction: bit 10 for A with mode at bits 12:11, bit 13 for B with mode at bits 15:14. The forced level appears after the second rising edge following the change on `ctrl_i`.
- R7: A fired one-shot level is held until an action event on that output. One edge after that event, the output returns to its raw level.
- R8: A trigger toggle with one-shot mode 0 or 3 changes nothing, and it does not clear a one-shot level already held.
- R9: An enabled continuous override takes priority over a held one-shot level and over the raw level.
- R10: If a trigger toggle and an action event on the same output fall in the same cycle, the new one-shot level is taken.
- R11: Outputs A and B are independent: triggers, modes and action events of one output do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_a_i | input | 1 | Generator level for output A |
| raw_b_i | input | 1 | Generator level for output B |
| act_a_i | input | 1 | Generator action event on output A |
| act_b_i | input | 1 | Generator action event on output B |
| ev_zero_i | input | 1 | Timer reached zero |
| ev_period_i | input | 1 | Timer reached period |
| ev_cmpa_i | input | 1 | Timer matched compare A |
| ev_cmpb_i | input | 1 | Timer matched compare B |
| ev_sync_i | input | 1 | Sync pulse |
| ctrl_i | input | 16 | Override control word |
| out_a_o | output | 1 | Final level for output A |
| out_b_o | output | 1 | Final level for output B |

## Verification
Two functions of one output can land on the same clock edge: a one-shot trigger toggle (seen from the registered control word) and a generator action event that would clear the held level. The bench first puts a high one-shot level on A with the raw level also high. It then toggles the trigger with mode low, and raises `act_a_i` exactly in the cycle in which the captured toggle is visible. The collision is judged by the output after that edge. Low means the new one-shot won. High, which equals the raw level, would mean the action event cleared it. A second overlap, an enabled continuous override on top of a held one-shot, is judged by watching the one-shot level come back once the continuous override is removed.

// File: rtl/pwm_force_pkg.sv
package pwm_force_pkg;
  localparam int unsigned NUM_OUT   = 2;
  localparam int unsigned NUM_EV    = 5;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned METH_W    = NUM_EV + 1;
  localparam int unsigned CMODE_LSB = METH_W;
  localparam int unsigned OS_LSB    = CMODE_LSB + NUM_OUT * MODE_W;
  localparam int unsigned OS_STRIDE = 1 + MODE_W;
  localparam int unsigned CTRL_W    = OS_LSB + NUM_OUT * OS_STRIDE;

  typedef enum logic [MODE_W-1:0] {
    FM_OFF     = 2'd0,
    FM_LOW     = 2'd1,
    FM_HIGH    = 2'd2,
    FM_OFF_ALT = 2'd3
  } fmode_e;

  function automatic logic fm_drives(input logic [MODE_W-1:0] m);
    return (m == FM_LOW) || (m == FM_HIGH);
  endfunction

  function automatic logic fm_level(input logic [MODE_W-1:0] m);
    return m == FM_HIGH;
  endfunction
endpackage

// File: rtl/force_cfg_buf.sv
module force_cfg_buf
  import pwm_force_pkg::*;
#(
  parameter int unsigned N_EV  = NUM_EV,
  parameter int unsigned N_OUT = NUM_OUT,
  localparam int unsigned MW   = N_EV + 1,
  localparam int unsigned SW   = N_OUT * MODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MW-1:0] meth_i,
  input  logic [SW-1:0] shadow_i,
  input  logic [N_EV-1:0] ev_i,
  output logic [SW-1:0] active_o,
  output logic [SW-1:0] eff_o
);
  logic          freeze, immediate, hit;
  logic [SW-1:0] active_q;

  assign freeze    = meth_i[N_EV];
  assign immediate = (meth_i == '0);
  assign hit       = |(meth_i[N_EV-1:0] & ev_i);

  // in immediate mode the active copy tracks so a later mask change keeps it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          active_q <= '0;
    else if (!freeze && (immediate || hit)) active_q <= shadow_i;
  end

  assign active_o = active_q;
  assign eff_o    = immediate ? shadow_i : active_q;
endmodule

// File: rtl/oneshot_force.sv
module oneshot_force
  import pwm_force_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              act_ev_i,
  output logic              toggle_o,
  output logic              valid_o,
  output logic              level_o
);
  logic prev_q, valid_q, level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= trig_i;
  end

  assign toggle_o = trig_i ^ prev_q;

  // a new force wins over a same-cycle action event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      level_q <= 1'b0;
    end else if (toggle_o && fm_drives(mode_i)) begin
      valid_q <= 1'b1;
      level_q <= fm_level(mode_i);
    end else if (act_ev_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign level_o = level_q;
endmodule

// File: rtl/force_out_mux.sv
module force_out_mux
  import pwm_force_pkg::*;
(
  input  logic              raw_i,
  input  logic [MODE_W-1:0] cmode_i,
  input  logic              os_valid_i,
  input  logic              os_level_i,
  output logic              out_o
);
  always_comb begin
    if (fm_drives(cmode_i)) out_o = fm_level(cmode_i);
    else if (os_valid_i)    out_o = os_level_i;
    else                    out_o = raw_i;
  end
endmodule

// File: rtl/pwm_force_ovr.sv
module pwm_force_ovr
  import pwm_force_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_a_i,
  input  logic              raw_b_i,
  input  logic              act_a_i,
  input  logic              act_b_i,
  input  logic              ev_zero_i,
  input  logic              ev_period_i,
  input  logic              ev_cmpa_i,
  input  logic              ev_cmpb_i,
  input  logic              ev_sync_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              out_a_o,
  output logic              out_b_o
);
  localparam int unsigned SW = NUM_OUT * MODE_W;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [METH_W-1:0]  meth;
  logic [SW-1:0]      shadow, active, eff;
  logic [NUM_EV-1:0]  ev;
  logic [NUM_OUT-1:0] raw, act_ev, out;
  logic [NUM_OUT-1:0] os_toggle, os_valid, os_level;
  logic [SW-1:0]      os_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_i;
  end

  assign meth   = ctrl_q[METH_W-1:0];
  assign shadow = ctrl_q[CMODE_LSB +: SW];
  assign ev     = {ev_sync_i, ev_cmpb_i, ev_cmpa_i, ev_period_i, ev_zero_i};
  assign raw    = {raw_b_i, raw_a_i};
  assign act_ev = {act_b_i, act_a_i};

  force_cfg_buf #(.N_EV(NUM_EV), .N_OUT(NUM_OUT)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .meth_i   (meth),
    .shadow_i (shadow),
    .ev_i     (ev),
    .active_o (active),
    .eff_o    (eff)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_ch
    assign os_mode[k*MODE_W +: MODE_W] = ctrl_q[OS_LSB + k*OS_STRIDE + 1 +: MODE_W];

    oneshot_force u_os (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (ctrl_q[OS_LSB + k*OS_STRIDE]),
      .mode_i   (os_mode[k*MODE_W +: MODE_W]),
      .act_ev_i (act_ev[k]),
      .toggle_o (os_toggle[k]),
      .valid_o  (os_valid[k]),
      .level_o  (os_level[k])
    );

    force_out_mux u_mux (
      .raw_i      (raw[k]),
      .cmode_i    (eff[k*MODE_W +: MODE_W]),
      .os_valid_i (os_valid[k]),
      .os_level_i (os_level[k]),
      .out_o      (out[k])
    );
  end

  assign out_a_o = out[0];
  assign out_b_o = out[1];
endmodule

// File: rtl/pwm_force_ovr_chk.sv
module pwm_force_ovr_chk
  import pwm_force_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_OUT-1:0]        raw_i,
  input logic [NUM_OUT-1:0]        out_i,
  input logic [NUM_OUT-1:0]        act_ev_i,
  input logic [METH_W-1:0]         meth_i,
  input logic [NUM_EV-1:0]         ev_i,
  input logic [NUM_OUT*MODE_W-1:0] shadow_i,
  input logic [NUM_OUT*MODE_W-1:0] active_i,
  input logic [NUM_OUT*MODE_W-1:0] eff_i,
  input logic [NUM_OUT-1:0]        os_toggle_i,
  input logic [NUM_OUT-1:0]        os_valid_i,
  input logic [NUM_OUT-1:0]        os_level_i,
  input logic [NUM_OUT*MODE_W-1:0] os_mode_i
);
  p_immediate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meth_i == '0) |-> (eff_i == shadow_i));

  p_event_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meth_i[NUM_EV] && |(meth_i[NUM_EV-1:0] & ev_i)) |=> (active_i == $past(shadow_i)));

  p_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meth_i[NUM_EV] |=> $stable(active_i));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_k
    p_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fm_drives(eff_i[k*MODE_W +: MODE_W]) && !os_valid_i[k]) |-> (out_i[k] == raw_i[k]));

    p_cont_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fm_drives(eff_i[k*MODE_W +: MODE_W]) |-> (out_i[k] == (eff_i[k*MODE_W +: MODE_W] == FM_HIGH)));

    p_fire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (os_toggle_i[k] && fm_drives(os_mode_i[k*MODE_W +: MODE_W]))
      |=> (os_valid_i[k] && (os_level_i[k] == $past(os_mode_i[k*MODE_W +: MODE_W] == FM_HIGH))));

    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_ev_i[k] && !os_toggle_i[k]) |=> !os_valid_i[k]);

    p_null_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (os_toggle_i[k] && !fm_drives(os_mode_i[k*MODE_W +: MODE_W]) && !act_ev_i[k])
      |=> ($stable(os_valid_i[k]) && $stable(os_level_i[k])));
  end
endmodule

bind pwm_force_ovr pwm_force_ovr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .raw_i       (raw),
  .out_i       (out),
  .act_ev_i    (act_ev),
  .meth_i      (meth),
  .ev_i        (ev),
  .shadow_i    (shadow),
  .active_i    (active),
  .eff_i       (eff),
  .os_toggle_i (os_toggle),
  .os_valid_i  (os_valid),
  .os_level_i  (os_level),
  .os_mode_i   (os_mode)
);

// File: tb/sim_pwm_force_ovr.sv
`timescale 1ns/1ps
module sim_pwm_force_ovr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw_a = 1'b0, raw_b = 1'b0, act_a = 1'b0, act_b = 1'b0;
  logic [4:0]  ev = '0;
  logic [15:0] cw = '0;
  logic        out_a, out_b;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  pwm_force_ovr u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .raw_a_i(raw_a), .raw_b_i(raw_b), .act_a_i(act_a), .act_b_i(act_b),
    .ev_zero_i(ev[0]), .ev_period_i(ev[1]), .ev_cmpa_i(ev[2]),
    .ev_cmpb_i(ev[3]), .ev_sync_i(ev[4]),
    .ctrl_i(cw), .out_a_o(out_a), .out_b_o(out_b)
  );

  typedef struct packed {
    logic [15:0] cw;
    logic        ra;
    logic        rb;
    logic        ea;
    logic        eb;
  } vec_t;

  // immediate-mode continuous settings (R2, R3)
  localparam vec_t VT [8] = '{
    '{16'h0000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h0240, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'h0180, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'h03C0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h00C0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{16'h0140, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h0280, 1'b0, 1'b0, 1'b1, 1'b1},
    '{16'h0200, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic pulse_ev(input logic [4:0] e);
    ev = e;
    tick(1);
    ev = '0;
  endtask

  task automatic pulse_act(input bit on_b);
    if (on_b) act_b = 1'b1; else act_a = 1'b1;
    tick(1);
    act_a = 1'b0;
    act_b = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    raw_a = 1'b1;
    raw_b = 1'b0;
    tick(2);
    chk(out_a, 1'b1, "R1", "in reset A");
    chk(out_b, 1'b0, "R1", "in reset B");
    rst_n = 1'b1;
    tick(1);
    raw_a = 1'b0;
    raw_b = 1'b1;
    #1;
    chk(out_a, 1'b0, "R1", "pass A");
    chk(out_b, 1'b1, "R1", "pass B");

    for (int i = 0; i < 8; i++) begin
      cw = VT[i].cw;
      raw_a = VT[i].ra;
      raw_b = VT[i].rb;
      tick(1);
      chk(out_a, VT[i].ea, "R2", $sformatf("vec %0d A", i));
      chk(out_b, VT[i].eb, "R3", $sformatf("vec %0d B", i));
    end

    // R4: each mask bit on its own
    for (int i = 0; i < 5; i++) begin
      cw = 16'h0000;
      raw_a = 1'b0;
      tick(2);
      cw = 16'h0080 | 16'(1 << i);
      tick(2);
      chk(out_a, 1'b0, "R4", $sformatf("bit %0d before event", i));
      pulse_ev(5'h1F & ~5'(1 << i));
      chk(out_a, 1'b0, "R4", $sformatf("bit %0d other events", i));
      pulse_ev(5'(1 << i));
      chk(out_a, 1'b1, "R4", $sformatf("bit %0d own event", i));
    end

    // R5: freeze
    cw = 16'h0080;
    tick(2);
    chk(out_a, 1'b1, "R5", "set high");
    cw = 16'h0060;
    tick(2);
    pulse_ev(5'h1F);
    chk(out_a, 1'b1, "R5", "frozen vs low shadow");
    cw = 16'h003F;
    tick(1);
    pulse_ev(5'h1F);
    chk(out_a, 1'b1, "R5", "frozen all bits");
    cw = 16'h0000;
    tick(1);
    chk(out_a, 1'b0, "R5", "released");

    // R6/R7 one-shot on A
    cw = 16'h0000;
    tick(2);
    cw = 16'h1400;
    tick(1);
    chk(out_a, 1'b0, "R6", "not yet");
    tick(1);
    chk(out_a, 1'b1, "R6", "rise toggle");
    tick(3);
    chk(out_a, 1'b1, "R7", "held");
    pulse_act(1'b0);
    chk(out_a, 1'b0, "R7", "cleared");
    raw_a = 1'b1;
    #1;
    chk(out_a, 1'b1, "R7", "raw after clear");
    raw_a = 1'b0;
    cw = 16'h1000;
    tick(2);
    chk(out_a, 1'b1, "R6", "fall toggle");
    pulse_act(1'b0);
    chk(out_a, 1'b0, "R7", "cleared again");

    // R8 null modes
    raw_a = 1'b1;
    cw = 16'h0C00;
    tick(2);
    chk(out_a, 1'b0, "R8", "low fired");
    cw = 16'h1800;
    tick(2);
    chk(out_a, 1'b0, "R8", "mode 3 keeps held");
    cw = 16'h0400;
    tick(2);
    chk(out_a, 1'b0, "R8", "mode 0 keeps held");
    pulse_act(1'b0);
    chk(out_a, 1'b1, "R7", "clear to raw");
    cw = 16'h1800;
    tick(2);
    chk(out_a, 1'b1, "R8", "mode 3 no force");

    // R9 continuous over one-shot
    raw_a = 1'b0;
    cw = 16'h1400;
    tick(2);
    chk(out_a, 1'b1, "R9", "one-shot high");
    cw = 16'h1440;
    tick(1);
    chk(out_a, 1'b0, "R9", "continuous low wins");
    cw = 16'h1400;
    tick(1);
    chk(out_a, 1'b1, "R9", "one-shot back");

    // R10 toggle and action in the same cycle
    raw_a = 1'b1;
    cw = 16'h0800;
    tick(1);
    act_a = 1'b1;
    tick(1);
    act_a = 1'b0;
    chk(out_a, 1'b0, "R10", "toggle wins");
    pulse_act(1'b0);
    chk(out_a, 1'b1, "R10", "later action clears");

    // R11 independence
    raw_a = 1'b0;
    raw_b = 1'b0;
    cw = 16'hA800;
    tick(2);
    chk(out_b, 1'b1, "R11", "B fired");
    chk(out_a, 1'b0, "R11", "A untouched");
    pulse_act(1'b0);
    chk(out_b, 1'b1, "R11", "A action keeps B");
    pulse_act(1'b1);
    chk(out_b, 1'b0, "R11", "B action clears");

    summary();
    $finish;
  end
endmodule